// File: doc/BRIEF.md
# Multiplexed Cell Threshold Sampler

This block sequences the measurement of a series stack of three or four cells through one shared analog path. Once per sample period it walks a one-hot select bus across the cell positions, so that an external multiplexer routes one cell at a time to three comparators. For each cell it waits a settling interval and then captures three comparator results: above the overvoltage level, below the charge-enable level, and below the undervoltage level.

When the last active cell of a scan has been captured, the block folds the per-cell results into three registered flags. Two of them are ORs across the active cells: any cell overvoltage and any cell undervoltage. The third is an AND: every cell below the charge-enable level. A strobe marks the cycle in which the flags change. A cell-count input selects three-cell or four-cell operation, and a sleep input halts scanning with every select line low. Time is counted in ticks of an external timebase enable, so the sample period (typically 40 ms) and the settling interval are parameters in ticks.

Top module: `cell_scan_seq`

## Requirements
- R1: While reset is asserted and after it is released, `cell_sel` is 0000, `scan_done` is 0 and all three flags (`any_ov`, `all_ce`, `any_uv`) are 0 until the first scan completes.
- R2: A free-running period counter advances on every `tick` and wraps after PERIOD_TICKS ticks; a scan begins on the tick at which the counter is at zero, so scans start exactly PERIOD_TICKS ticks apart.
- R3: During a scan `cell_sel` is one-hot, bit i selecting cell position i, visiting positions in ascending order from bit 0; each position is held for SETTLE_TICKS ticks and the comparator inputs are captured only at the clock edge of the last of those ticks; comparator values at any other time have no effect.
- R4: With `four_cell` = 0 only positions 0 to 2 are scanned, `cell_sel[3]` never rises and comparator values never reach the flags from position 3; with `four_cell` = 1 all four positions are scanned.
- R5: `four_cell` is sampled when a scan begins; changing it during a scan affects only later scans.
- R6: `any_ov` becomes the OR of the overvoltage results of the active cells of the completed scan.
- R7: `all_ce` becomes 1 only when every active cell of the completed scan reported below the charge-enable level.
- R8: `any_uv` becomes the OR of the undervoltage results of the active cells of the completed scan.
- R9: The three flags change together one clock after the last active cell is captured, in the same cycle that `scan_done` is high for exactly one clock; at all other times the flags hold.
- R10: While `sleep` is high, from the next clock `cell_sel` is 0000, any scan in progress is abandoned without touching the flags or pulsing `scan_done`, and the period counter is held at zero, so the first tick after `sleep` falls starts a fresh scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase enable, one clock wide |
| sleep | input | 1 | Halt scanning, select lines low |
| four_cell | input | 1 | 1 = four cells, 0 = three cells |
| cmp_ov | input | 1 | Selected cell is above the overvoltage level |
| cmp_ce_low | input | 1 | Selected cell is below the charge-enable level |
| cmp_uv | input | 1 | Selected cell is below the undervoltage level |
| cell_sel | output | 4 | One-hot cell select to the analog multiplexer |
| any_ov | output | 1 | Some active cell above overvoltage in the last scan |
| all_ce | output | 1 | Every active cell below charge-enable in the last scan |
| any_uv | output | 1 | Some active cell below undervoltage in the last scan |
| scan_done | output | 1 | One-clock strobe when the flags are updated |

## Verification
The hardest cases to reach from the ports are the ones where the cell count or sleep changes while a particular position is selected, because the outcome depends on which cell the scan has reached. The bench waits for the select bus to show the wanted position, changes the control input right after the next clock edge, and then relies on a behavioural reference model, fed the same pins, to predict the abandoned or completed scan. A fourth-position comparator pattern that would flip every flag is driven during three-cell scans so that any leak shows up at the outputs.

// File: rtl/cs_pkg.sv
package cs_pkg;
  localparam int unsigned CELL_POS = 4;
  localparam int unsigned IDX_W = 2;

  typedef struct packed {
    logic ov;
    logic ce_low;
    logic uv;
  } cell_res_t;

  typedef struct packed {
    logic any_ov;
    logic all_ce;
    logic any_uv;
  } flags_t;

  typedef enum logic [1:0] {ST_IDLE, ST_SETTLE, ST_FINAL} scan_st_t;

  localparam cell_res_t RES_NEUTRAL = '{ov: 1'b0, ce_low: 1'b1, uv: 1'b0};

  function automatic logic [CELL_POS-1:0] sel_of(input logic [IDX_W-1:0] idx);
    return {{(CELL_POS-1){1'b0}}, 1'b1} << idx;
  endfunction

  function automatic logic [IDX_W-1:0] last_idx(input logic four);
    return four ? IDX_W'(CELL_POS - 1) : IDX_W'(CELL_POS - 2);
  endfunction

  function automatic logic [CELL_POS-1:0] active_mask(input logic four);
    return four ? {CELL_POS{1'b1}} : {1'b0, {(CELL_POS-1){1'b1}}};
  endfunction

  function automatic flags_t fold(input cell_res_t [CELL_POS-1:0] r,
                                  input logic [CELL_POS-1:0] mask);
    flags_t f;
    f = '{any_ov: 1'b0, all_ce: 1'b1, any_uv: 1'b0};
    for (int i = 0; i < CELL_POS; i++) begin
      if (mask[i]) begin
        f.any_ov = f.any_ov | r[i].ov;
        f.all_ce = f.all_ce & r[i].ce_low;
        f.any_uv = f.any_uv | r[i].uv;
      end
    end
    return f;
  endfunction
endpackage

// File: rtl/cs_period_timer.sv
module cs_period_timer #(
  parameter int unsigned PERIOD_TICKS = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic sleep,
  output logic scan_start
);
  localparam int unsigned PW = (PERIOD_TICKS > 2) ? $clog2(PERIOD_TICKS) : 1;
  localparam logic [PW-1:0] P_LAST = PW'(PERIOD_TICKS - 1);

  logic [PW-1:0] pcnt;

  assign scan_start = tick & ~sleep & (pcnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pcnt <= '0;
    else if (sleep)   pcnt <= '0;
    else if (tick)    pcnt <= (pcnt == P_LAST) ? '0 : pcnt + 1'b1;
  end
endmodule

// File: rtl/cs_scan_ctl.sv
module cs_scan_ctl
  import cs_pkg::*;
#(
  parameter int unsigned SETTLE_TICKS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 sleep,
  input  logic                 scan_start,
  input  logic                 four_cell,
  output logic [CELL_POS-1:0]  cell_sel,
  output logic [IDX_W-1:0]     cur_idx,
  output logic                 scan_begin,
  output logic                 latch_evt,
  output logic                 finish_evt,
  output logic                 scan_four
);
  localparam int unsigned SW = (SETTLE_TICKS > 2) ? $clog2(SETTLE_TICKS) : 1;
  localparam logic [SW-1:0] S_LAST = SW'(SETTLE_TICKS - 1);

  scan_st_t       st;
  logic [SW-1:0]  scnt;
  logic           last_cell;

  assign last_cell  = (cur_idx == last_idx(scan_four));
  assign scan_begin = (st == ST_IDLE) & scan_start;
  assign latch_evt  = (st == ST_SETTLE) & tick & ~sleep & (scnt == S_LAST);
  assign finish_evt = (st == ST_FINAL) & ~sleep;
  assign cell_sel   = (st == ST_SETTLE) ? sel_of(cur_idx) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      scnt      <= '0;
      cur_idx   <= '0;
      scan_four <= 1'b0;
    end else if (sleep) begin
      st      <= ST_IDLE;
      scnt    <= '0;
      cur_idx <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (scan_begin) begin
            st        <= ST_SETTLE;
            scnt      <= '0;
            cur_idx   <= '0;
            scan_four <= four_cell;
          end
        end
        ST_SETTLE: begin
          if (latch_evt) begin
            scnt <= '0;
            if (last_cell) st <= ST_FINAL;
            else           cur_idx <= cur_idx + 1'b1;
          end else if (tick) begin
            scnt <= scnt + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cs_result_acc.sv
module cs_result_acc
  import cs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_begin,
  input  logic              latch_evt,
  input  logic [IDX_W-1:0]  cur_idx,
  input  logic              cmp_ov,
  input  logic              cmp_ce_low,
  input  logic              cmp_uv,
  input  logic              finish_evt,
  input  logic              scan_four,
  output flags_t            flags,
  output logic              scan_done
);
  cell_res_t [CELL_POS-1:0] scratch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scratch <= {CELL_POS{RES_NEUTRAL}};
    end else if (scan_begin) begin
      scratch <= {CELL_POS{RES_NEUTRAL}};
    end else if (latch_evt) begin
      scratch[cur_idx] <= '{ov: cmp_ov, ce_low: cmp_ce_low, uv: cmp_uv};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags     <= '0;
      scan_done <= 1'b0;
    end else begin
      scan_done <= finish_evt;
      if (finish_evt) flags <= fold(scratch, active_mask(scan_four));
    end
  end
endmodule

// File: rtl/cell_scan_seq.sv
module cell_scan_seq
  import cs_pkg::*;
#(
  parameter int unsigned PERIOD_TICKS = 40,
  parameter int unsigned SETTLE_TICKS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       sleep,
  input  logic       four_cell,
  input  logic       cmp_ov,
  input  logic       cmp_ce_low,
  input  logic       cmp_uv,
  output logic [3:0] cell_sel,
  output logic       any_ov,
  output logic       all_ce,
  output logic       any_uv,
  output logic       scan_done
);
  logic             scan_start;
  logic             scan_begin;
  logic             latch_evt;
  logic             finish_evt;
  logic             scan_four;
  logic [IDX_W-1:0] cur_idx;
  flags_t           flags;

  cs_period_timer #(.PERIOD_TICKS(PERIOD_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sleep(sleep), .scan_start(scan_start)
  );

  cs_scan_ctl #(.SETTLE_TICKS(SETTLE_TICKS)) u_ctl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sleep(sleep),
    .scan_start(scan_start), .four_cell(four_cell),
    .cell_sel(cell_sel), .cur_idx(cur_idx), .scan_begin(scan_begin),
    .latch_evt(latch_evt), .finish_evt(finish_evt), .scan_four(scan_four)
  );

  cs_result_acc u_acc (
    .clk(clk), .rst_n(rst_n), .scan_begin(scan_begin), .latch_evt(latch_evt),
    .cur_idx(cur_idx), .cmp_ov(cmp_ov), .cmp_ce_low(cmp_ce_low), .cmp_uv(cmp_uv),
    .finish_evt(finish_evt), .scan_four(scan_four),
    .flags(flags), .scan_done(scan_done)
  );

  assign any_ov = flags.any_ov;
  assign all_ce = flags.all_ce;
  assign any_uv = flags.any_uv;
endmodule

// File: rtl/cell_scan_seq_chk.sv
module cell_scan_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sleep,
  input logic [3:0] cell_sel,
  input logic       scan_done,
  input logic       any_ov,
  input logic       all_ce,
  input logic       any_uv,
  input logic       latch_evt,
  input logic       finish_evt,
  input logic       scan_four
);
  a_r3_onehot_sel: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cell_sel));

  a_r3_latch_on_selected: assert property (@(posedge clk) disable iff (!rst_n)
    latch_evt |-> $onehot(cell_sel));

  a_r4_no_fourth_in_three: assert property (@(posedge clk) disable iff (!rst_n)
    cell_sel[3] |-> scan_four);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |=> !scan_done);

  a_r9_finish_gives_done: assert property (@(posedge clk) disable iff (!rst_n)
    finish_evt |=> scan_done);

  a_r9_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_done |-> $stable({any_ov, all_ce, any_uv}));

  a_r10_sleep_sel_low: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> (cell_sel == 4'b0000) && !scan_done);
endmodule

bind cell_scan_seq cell_scan_seq_chk u_chk (.*);

// File: tb/cell_scan_seq_bench.sv
module cell_scan_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PER = 20;
  localparam int SET = 3;

  logic clk = 0, rst_n = 0, tick = 0, sleep = 0, four_cell = 1;
  logic cmp_ov = 0, cmp_ce_low = 0, cmp_uv = 0;
  logic [3:0] cell_sel;
  logic any_ov, all_ce, any_uv, scan_done;

  cell_scan_seq #(.PERIOD_TICKS(PER), .SETTLE_TICKS(SET)) u_cell_scan_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sleep(sleep), .four_cell(four_cell),
    .cmp_ov(cmp_ov), .cmp_ce_low(cmp_ce_low), .cmp_uv(cmp_uv),
    .cell_sel(cell_sel), .any_ov(any_ov), .all_ce(all_ce), .any_uv(any_uv),
    .scan_done(scan_done));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;

  // stimulus controls (set by the main sequence, applied at falling edges)
  int  tick_mode = 0;       // 0 every clock, 1 alternate, 2 random
  bit  sleep_v = 0, four_v = 1;
  bit  vov[4], vce[4], vuv[4];
  bit  tick_tog = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // reference model: behavioural, fed from the same pins
  int  m_pc, m_phase, m_cell, m_wait;
  bit  m_four, m_done, m_ov, m_ce, m_uv;
  bit  r_ov[4], r_ce[4], r_uv[4];
  bit  model_live = 0;

  always @(posedge clk) begin
    bit st;
    if (!rst_n) begin
      m_pc = 0; m_phase = 0; m_cell = 0; m_wait = 0; m_four = 0;
      m_done = 0; m_ov = 0; m_ce = 0; m_uv = 0;
    end else begin
      m_done = 0;
      if (sleep) begin
        m_pc = 0; m_phase = 0;
      end else begin
        st = tick && (m_pc == 0);
        if (tick) m_pc = (m_pc + 1) % PER;
        if (m_phase == 0) begin
          if (st) begin
            m_phase = 1; m_cell = 0; m_wait = 0; m_four = four_cell;
            for (int i = 0; i < 4; i++) begin r_ov[i] = 0; r_ce[i] = 1; r_uv[i] = 0; end
          end
        end else if (m_phase == 1) begin
          if (tick) begin
            if (m_wait == SET - 1) begin
              r_ov[m_cell] = cmp_ov; r_ce[m_cell] = cmp_ce_low; r_uv[m_cell] = cmp_uv;
              if (m_cell == (m_four ? 3 : 2)) m_phase = 2;
              else begin m_cell++; m_wait = 0; end
            end else m_wait++;
          end
        end else begin
          int n;
          n = m_four ? 4 : 3;
          m_ov = 0; m_ce = 1; m_uv = 0;
          for (int i = 0; i < n; i++) begin
            if (r_ov[i]) m_ov = 1;
            if (!r_ce[i]) m_ce = 0;
            if (r_uv[i]) m_uv = 1;
          end
          m_done = 1; m_phase = 0;
        end
      end
    end
  end

  // compare, then drive inputs, at every falling edge
  always @(negedge clk) begin
    int exp_sel;
    if (model_live && rst_n) begin
      exp_sel = (m_phase == 1) ? (1 << m_cell) : 0;
      chk(cell_sel == 4'(exp_sel), "R3 cell_sel vs model", cell_sel, exp_sel);
      chk(scan_done == m_done, "R9 scan_done vs model", scan_done, m_done);
      chk(any_ov == m_ov, "R6 any_ov vs model", any_ov, m_ov);
      chk(all_ce == m_ce, "R7 all_ce vs model", all_ce, m_ce);
      chk(any_uv == m_uv, "R8 any_uv vs model", any_uv, m_uv);
    end
    sleep <= sleep_v;
    four_cell <= four_v;
    tick_tog = ~tick_tog;
    tick <= (tick_mode == 0) ? 1'b1 : (tick_mode == 1) ? tick_tog : ($urandom % 3 == 0);
    if (cell_sel == 4'b0000) begin
      cmp_ov <= $urandom; cmp_ce_low <= $urandom; cmp_uv <= $urandom;
    end else begin
      for (int i = 0; i < 4; i++)
        if (cell_sel[i]) begin cmp_ov <= vov[i]; cmp_ce_low <= vce[i]; cmp_uv <= vuv[i]; end
    end
  end

  task automatic set_cells(input bit [3:0] ov, input bit [3:0] ce, input bit [3:0] uv);
    for (int i = 0; i < 4; i++) begin vov[i] = ov[i]; vce[i] = ce[i]; vuv[i] = uv[i]; end
  endtask

  task automatic wait_done();
    int n = 0;
    do begin @(negedge clk); n++; end while (!scan_done && n < 5000);
    chk(scan_done == 1, "R9 scan completes", scan_done, 1);
  endtask

  task automatic wait_sel(input int pos);
    int n = 0;
    do begin @(negedge clk); n++; end while (!cell_sel[pos] && n < 5000);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired t=%0t", $time);
    finish_run();
  end

  initial begin
    int t0, t1;
    bit s_ov, s_ce, s_uv;
    set_cells(4'b0000, 4'b1111, 4'b0000);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cell_sel == 0, "R1 reset cell_sel", cell_sel, 0);
    chk({any_ov, all_ce, any_uv} == 3'b000, "R1 reset flags", {any_ov, all_ce, any_uv}, 0);
    chk(scan_done == 0, "R1 reset scan_done", scan_done, 0);
    @(posedge clk); rst_n = 1; model_live = 1;
    @(negedge clk); @(negedge clk);
    chk(cell_sel == 4'b0001, "R2 first scan starts at count zero", cell_sel, 1);

    // R6/R7/R8 healthy four-cell pack
    wait_done();
    chk({any_ov, all_ce, any_uv} == 3'b010, "R7 healthy four cells", {any_ov, all_ce, any_uv}, 2);
    t0 = $time / CLK_PERIOD;
    // R2 period with a tick every clock
    set_cells(4'b0100, 4'b1011, 4'b0000);
    wait_done();
    t1 = $time / CLK_PERIOD;
    chk(t1 - t0 == PER, "R2 scan spacing", t1 - t0, PER);
    chk(any_ov == 1, "R6 cell 2 overvoltage", any_ov, 1);
    chk(all_ce == 0, "R7 one cell above charge-enable", all_ce, 0);

    // R8 undervoltage on cell 0, alternate ticks
    tick_mode = 1;
    set_cells(4'b0000, 4'b1111, 4'b0001);
    wait_done(); wait_done();
    chk({any_ov, all_ce, any_uv} == 3'b011, "R8 cell 0 undervoltage", {any_ov, all_ce, any_uv}, 3);

    // R4 three-cell mode: position 3 carries values that would flip every flag
    tick_mode = 0;
    @(posedge clk); four_v = 0;
    set_cells(4'b1000, 4'b0111, 4'b1000);
    wait_done(); wait_done();
    chk({any_ov, all_ce, any_uv} == 3'b010, "R4 fourth cell ignored", {any_ov, all_ce, any_uv}, 2);

    // R5 mode switched mid-scan: four-cell scan must still include cell 3
    @(posedge clk); four_v = 1;
    wait_done();
    wait_sel(0);
    @(posedge clk); four_v = 0;
    wait_done();
    chk(any_ov == 1, "R5 mode held through scan", any_ov, 1);
    wait_done();
    chk(any_ov == 0, "R5 new mode on next scan", any_ov, 0);

    // R10 sleep mid-scan
    @(posedge clk); four_v = 1; set_cells(4'b1111, 4'b0000, 4'b1111);
    wait_sel(1);
    s_ov = any_ov; s_ce = all_ce; s_uv = any_uv;
    @(posedge clk); sleep_v = 1;
    @(negedge clk); @(negedge clk);
    chk(cell_sel == 0, "R10 select low in sleep", cell_sel, 0);
    repeat (100) begin
      @(negedge clk);
      if (scan_done) chk(0, "R10 no done in sleep", 1, 0);
    end
    chk({any_ov, all_ce, any_uv} == {s_ov, s_ce, s_uv}, "R10 flags kept",
        {any_ov, all_ce, any_uv}, {s_ov, s_ce, s_uv});
    @(posedge clk); sleep_v = 0;
    @(negedge clk); @(negedge clk);
    chk(cell_sel == 4'b0001, "R10 fresh scan after wake", cell_sel, 1);
    wait_done();
    chk({any_ov, all_ce, any_uv} == 3'b101, "R6 R8 all cells failing", {any_ov, all_ce, any_uv}, 5);

    // random ticks, modes and cell values; model comparison covers R3 and R9
    tick_mode = 2;
    for (int k = 0; k < 30; k++) begin
      @(posedge clk);
      four_v = $urandom;
      set_cells(4'($urandom), 4'($urandom), 4'($urandom));
      wait_done();
    end
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule